// File: doc/BRIEF.md
# Two-Bit JK Mealy Sequence Machine

This block is a small synchronous state machine with one serial input and one output. Two JK flip-flop cells hold its state. A fixed set of excitation equations drives the J and K pins of both cells from the present state and the serial input. The block is built from a reusable JK cell. That cell updates on the rising clock edge and has active-low direct set and clear pins. The pins act without waiting for the clock.

A high level on the reset input pulls the direct clear of both cells low, so the machine drops to state 00 at once. The direct set pins are tied inactive. The output is of the Mealy kind: it is formed from the present state and the present input. It can therefore change between clock edges whenever the input moves. The four excitation signals and the two state bits are brought out so that they can be observed.

Top module: `jk_seq_machine`

## Requirements
- R1: While `rst` is 1, `state` is 00, and this takes effect asynchronously without waiting for a clock edge. `rst` held high across rising edges keeps `state` at 00 whatever `x` is.
- R2: Each state bit follows the JK rule at every rising edge outside reset. With J and K sampled at that edge, JK=00 keeps the bit, JK=01 clears it, JK=10 sets it and JK=11 inverts it. `state[1]` is driven by `j1`/`k1` and `state[0]` by `j0`/`k0`.
- R3: The excitation outputs are combinational in `x` and `state`: `j1` = (not x) and state[0], `k1` = x or state[0], `j0` = x or state[1], `k0` = not x.
- R4: A rising edge outside reset with `x`=1 moves the machine to state 01 from every state.
- R5: A rising edge outside reset with `x`=0 steps the machine from 00 to 00, from 01 to 10, from 10 to 11 and from 11 to 00.
- R6: `z` is 1 exactly when `state` is 11 and `x` is 1. It follows `x` combinationally within a cycle, with no clock edge needed.
- R7: Only the value of `x` at the rising edge affects the next state. Changes of `x` between edges leave `state` untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high asynchronous reset to state 00 |
| x | input | 1 | Serial input |
| z | output | 1 | Mealy output |
| state | output | 2 | Present state, bit 1 = high cell, bit 0 = low cell |
| j1 | output | 1 | J excitation of the high cell |
| k1 | output | 1 | K excitation of the high cell |
| j0 | output | 1 | J excitation of the low cell |
| k0 | output | 1 | K excitation of the low cell |

## Verification
Two things coincide in state 11 when `x` is 1: the output pulses high, and at the same rising edge the machine leaves for 01. The bench reaches state 11 through the x=0 walk. It then holds `x` at 1 across an edge, checks `z` before that edge and checks the 01 state after it, so both effects are judged on the same cycle. The second overlap is between a reset held over a rising edge and the JK update of that edge when `x`=1. The excitations then call for a set, and the bench expects the state to stay at 00.

// File: rtl/jk_seq_pkg.sv
`timescale 1ns/1ps
package jk_seq_pkg;
    localparam int STATE_W = 2;
    localparam int HI_BIT  = STATE_W - 1;
    localparam int LO_BIT  = 0;

    typedef struct packed {
        logic j;
        logic k;
    } jk_pair_t;

    typedef jk_pair_t [STATE_W-1:0] jk_vec_t;
endpackage

// File: rtl/jk_cell.sv
`timescale 1ns/1ps
module jk_cell
    import jk_seq_pkg::*;
(
    input  logic     clk,
    input  logic     set_n,
    input  logic     clr_n,
    input  jk_pair_t ctl,
    output logic     q
);
    logic bit_d, bit_q;

    // next value from the JK pair and the stored bit
    always_comb begin
        unique case ({ctl.j, ctl.k})
            2'b00:   bit_d = bit_q;
            2'b01:   bit_d = 1'b0;
            2'b10:   bit_d = 1'b1;
            default: bit_d = ~bit_q;
        endcase
    end

    // direct pins act without the clock; clear wins over set
    always_ff @(posedge clk or negedge set_n or negedge clr_n) begin
        if (!clr_n)      bit_q <= 1'b0;
        else if (!set_n) bit_q <= 1'b1;
        else             bit_q <= bit_d;
    end

    assign q = bit_q;
endmodule

// File: rtl/jk_excite.sv
`timescale 1ns/1ps
module jk_excite
    import jk_seq_pkg::*;
(
    input  logic               x,
    input  logic [STATE_W-1:0] st,
    output jk_vec_t            exc
);
    always_comb begin
        exc[HI_BIT].j = ~x & st[LO_BIT];
        exc[HI_BIT].k =  x | st[LO_BIT];
        exc[LO_BIT].j =  x | st[HI_BIT];
        exc[LO_BIT].k = ~x;
    end
endmodule

// File: rtl/jk_seq_machine.sv
`timescale 1ns/1ps
module jk_seq_machine
    import jk_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               x,
    output logic               z,
    output logic [STATE_W-1:0] state,
    output logic               j1,
    output logic               k1,
    output logic               j0,
    output logic               k0
);
    logic               clr_n;
    logic               set_n;
    logic [STATE_W-1:0] st_q;
    jk_vec_t            exc;

    assign clr_n = ~rst;
    assign set_n = 1'b1;

    jk_excite u_excite (
        .x   (x),
        .st  (st_q),
        .exc (exc)
    );

    for (genvar i = 0; i < STATE_W; i++) begin : g_cell
        jk_cell u_cell (
            .clk   (clk),
            .set_n (set_n),
            .clr_n (clr_n),
            .ctl   (exc[i]),
            .q     (st_q[i])
        );
    end

    // Mealy output: present state and present input
    assign z     = (&st_q) & x;
    assign state = st_q;
    assign j1    = exc[HI_BIT].j;
    assign k1    = exc[HI_BIT].k;
    assign j0    = exc[LO_BIT].j;
    assign k0    = exc[LO_BIT].k;
endmodule

// File: rtl/jk_seq_checker.sv
`timescale 1ns/1ps
module jk_seq_checker (
    input logic       clk,
    input logic       rst,
    input logic       x,
    input logic       z,
    input logic [1:0] state,
    input logic       j1,
    input logic       k1,
    input logic       j0,
    input logic       k0
);
    function automatic logic [1:0] walk_next(input logic [1:0] s);
        case (s)
            2'd1:    walk_next = 2'd2;
            2'd2:    walk_next = 2'd3;
            default: walk_next = 2'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) assert_reset_state_R1: assert (state == 2'b00);
    end

    assert_cell_hi_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> state[1] == (($past(j1) && !$past(state[1])) ||
                              (!$past(k1) && $past(state[1]))));

    assert_cell_lo_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> state[0] == (($past(j0) && !$past(state[0])) ||
                              (!$past(k0) && $past(state[0]))));

    assert_load_one_R4: assert property (@(posedge clk) disable iff (rst)
        x |=> state == 2'b01);

    assert_walk_R5: assert property (@(posedge clk) disable iff (rst)
        !x |=> state == walk_next($past(state)));

    assert_pulse_exit_R6: assert property (@(posedge clk) disable iff (rst)
        z |=> state == 2'b01);
endmodule

bind jk_seq_machine jk_seq_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .x     (x),
    .z     (z),
    .state (state),
    .j1    (j1),
    .k1    (k1),
    .j0    (j0),
    .k0    (k0)
);

// File: tb/jk_seq_machine_test.sv
`timescale 1ns/1ps
module jk_seq_machine_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       x   = 1'b0;
    logic       z;
    logic [1:0] state;
    logic       j1, k1, j0, k0;

    int total = 0;
    int bad   = 0;
    logic finished = 1'b0;
    logic [1:0] m_state = 2'b00;
    logic [1:0] exp_q[$];

    jk_seq_machine uut (
        .clk(clk), .rst(rst), .x(x), .z(z), .state(state),
        .j1(j1), .k1(k1), .j0(j0), .k0(k0)
    );

    always #5 clk = ~clk;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference table from R4 and R5
    function automatic logic [1:0] ref_next(input logic [1:0] s, input logic xv);
        if (xv) return 2'b01;
        case (s)
            2'd0: return 2'd0;
            2'd1: return 2'd2;
            2'd2: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    task automatic check_comb();
        chk(j1 == (~x & m_state[0]), "R3 j1", j1, ~x & m_state[0]);
        chk(k1 == (x | m_state[0]),  "R3 k1", k1, x | m_state[0]);
        chk(j0 == (x | m_state[1]),  "R3 j0", j0, x | m_state[1]);
        chk(k0 == ~x,                "R3 k0", k0, ~x);
        chk(z == ((m_state == 2'b11) && x), "R6 z", z, (m_state == 2'b11) && x);
    endtask

    // driver: set x for one cycle, check comb outputs, queue expected state
    task automatic step(input logic xv);
        @(negedge clk);
        x = xv;
        #1;
        check_comb();
        exp_q.push_back(ref_next(m_state, xv));
        m_state = ref_next(m_state, xv);
    endtask

    // R7: x toggles between edges, only the final level counts
    task automatic glitch_step(input logic xv);
        @(negedge clk);
        x = ~xv; #1;
        x = xv;  #1;
        x = ~xv; #1;
        x = xv;  #1;
        check_comb();
        exp_q.push_back(ref_next(m_state, xv));
        m_state = ref_next(m_state, xv);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        #1;
        chk(state == 2'b00, "R1 async clear", state, 0);
        x = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk(state == 2'b00, "R1 held over edges", state, 0);
        rst = 1'b0;
        x = 1'b0;
        m_state = 2'b00;
    endtask

    task automatic reach(input logic [1:0] s);
        if (s >= 2'd1) step(1'b1);
        if (s >= 2'd2) step(1'b0);
        if (s == 2'd3) step(1'b0);
    endtask

    // monitor: compare state after each edge against the queue
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [1:0] e;
            e = exp_q.pop_front();
            chk(state == e, "R2 R4 R5 state", state, e);
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(state == 2'b00, "R1 reset state", state, 0);
        rst = 1'b0;

        // every present state with every input value
        for (int s = 0; s < 4; s++) begin
            for (int xv = 0; xv < 2; xv++) begin
                do_reset();
                reach(2'(s));
                step(1'(xv));
            end
        end

        // R6: z follows x inside one cycle in state 11, then the R4 exit
        do_reset();
        reach(2'd3);
        @(negedge clk);
        x = 1'b1; #1;
        chk(z == 1'b1, "R6 z high in 11", z, 1);
        x = 1'b0; #1;
        chk(z == 1'b0, "R6 z low between edges", z, 0);
        x = 1'b1; #1;
        chk(z == 1'b1, "R6 z high again", z, 1);
        exp_q.push_back(2'b01);
        m_state = 2'b01;
        @(negedge clk);
        chk(state == 2'b01 && z == 1'b0, "R4 exit after pulse", state, 1);

        // R7: glitches between edges
        do_reset();
        glitch_step(1'b1);
        glitch_step(1'b0);
        glitch_step(1'b0);
        glitch_step(1'b1);
        glitch_step(1'b0);

        // R1: asynchronous reset from a non-zero state
        do_reset();
        reach(2'd2);
        @(negedge clk);
        #2;
        rst = 1'b1;
        #1;
        chk(state == 2'b00, "R1 mid-cycle clear", state, 0);
        @(negedge clk);
        rst = 1'b0;
        m_state = 2'b00;

        // mixed run
        for (int i = 0; i < 40; i++) step(((i * 7 + 3) % 5) < 2);

        @(posedge clk);
        #4;
        chk(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule